// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with 10-bit Instruction Register

This block is the serial test access port of a chip. It runs the standard sixteen-state test controller on the test clock and the mode-select input. Instructions and data are shifted in on the serial input and out on the serial output. The instruction register is 10 bits wide and decodes a fixed opcode map of six instructions.

The instructions select one of four data paths. The first is a 1-bit bypass stage. The second and third are 32-bit identification and user-code words. The fourth is a boundary register whose length is a parameter. On the pin side, the boundary register appears as three things: a parallel capture vector taken from the pads, a hold register that can drive the pad outputs in place of the core, and a single high-impedance request for all output drivers.

An optional active-low asynchronous reset puts the controller into Test-Logic-Reset. Holding the mode-select input high for five clocks does the same from any state.

Top module: `jtag_tap`

## Requirements
- R1: The controller follows the standard sixteen-state transition graph, advancing on each rising `tck_i` edge according to `tms_i`. Five consecutive rising edges with `tms_i` high always end in Test-Logic-Reset.
- R2: Asserting `rst_ni` low, or being in Test-Logic-Reset, loads the IDCODE opcode 00_0000_0110 as the active instruction. In that state `highz_o` is 0 and `pin_out_o` follows `core_out_i`.
- R3: Capture-IR loads 00_0000_0001 into the instruction shift register, so the first ten bits shifted out in Shift-IR are 1,0,0,0,0,0,0,0,0,0.
- R4: In Shift-IR, `tdi_i` enters at bit 9 and bit 0 leaves on `tdo_o`. The shifted opcode becomes the active instruction on the rising edge that leaves Update-IR.
- R5: Under IDCODE (00_0000_0110), Capture-DR loads the 32-bit `IDCODE_VAL`, which is shifted out least significant bit first.
- R6: Under USERCODE (00_0000_0111), Capture-DR loads the 32-bit `USERCODE_VAL`, which is shifted out least significant bit first.
- R7: BYPASS (11_1111_1111) and every opcode not in the map select a 1-bit register that captures 0. As a result, `tdo_o` repeats `tdi_i` one clock later during Shift-DR.
- R8: HIGHZ (00_0000_1011) selects the bypass register and holds `highz_o` at 1 for as long as it is the active instruction. `highz_o` is 0 under every other instruction.
- R9: SAMPLE/PRELOAD (00_0000_0101) makes Capture-DR load `pin_in_i` into the boundary register, with bit 0 shifted out first. Update-DR loads the hold register, while `pin_out_o` keeps following `core_out_i`.
- R10: EXTEST (00_0000_0000) captures `pin_in_i` in the same way. While EXTEST is active, `pin_out_o` is driven from the boundary hold register.
- R11: `tdo_o` and `tdo_en_o` change only on falling `tck_i` edges. `tdo_en_o` is 1 only in Shift-IR or Shift-DR, and `tdo_o` is 0 whenever `tdo_en_o` is 0.
- R12: The boundary hold register changes only on the rising edge that leaves Update-DR while a boundary instruction is active. Shifting or pausing a scan leaves `pin_out_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Optional asynchronous test reset, active low |
| tms_i | input | 1 | Mode select, sampled on rising `tck_i` |
| tdi_i | input | 1 | Serial data in, sampled on rising `tck_i` |
| tdo_o | output | 1 | Serial data out, updated on falling `tck_i` |
| tdo_en_o | output | 1 | Output enable for `tdo_o` |
| pin_in_i | input | BSR_LEN | Pad input values seen by the boundary cells |
| core_out_i | input | BSR_LEN | Functional output values from the core |
| pin_out_o | output | BSR_LEN | Values driven to the pad outputs |
| highz_o | output | 1 | Request to tristate all output drivers |

## Verification
Serial output bits are due from the falling edge that follows entry into Shift-IR or Shift-DR, and one new bit follows on each later falling edge. The bench drives `tms_i` and `tdi_i` and samples `tdo_o` 1 ns after each falling edge, so each sampled bit is the one that the next rising edge shifts. `highz_o` and `pin_out_o` are registered, so they change on the rising edge that leaves Update-IR or Update-DR. The bench checks them once the controller is back in Run-Test/Idle, and checks the hold value again in the middle of a paused scan. Random instruction and data sequences are compared against bench functions that model the capture values, the one-bit bypass delay, the hold register and the high-impedance flag.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;
  localparam int IR_W = 10;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDCODE, DR_USER, DR_BSR} dr_sel_e;

  localparam logic [IR_W-1:0] OP_EXTEST   = 10'b00_0000_0000;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 10'b00_0000_0101;
  localparam logic [IR_W-1:0] OP_IDCODE   = 10'b00_0000_0110;
  localparam logic [IR_W-1:0] OP_USERCODE = 10'b00_0000_0111;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 10'b00_0000_1011;
  localparam logic [IR_W-1:0] OP_BYPASS   = 10'b11_1111_1111;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 10'b00_0000_0001;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e nxt;

  always_comb begin
    nxt = state_o;
    unique case (state_o)
      ST_TLR:    nxt = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms_i ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nxt = tms_i ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nxt = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms_i ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nxt = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms_i ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nxt = tms_i ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nxt = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms_i ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: nxt = tms_i ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) state_o <= ST_TLR;
    else         state_o <= nxt;
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_tap_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o,
  output logic [IR_W-1:0] sr_o
);
  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) sr_o <= '0;
    else if (state_i == ST_CAP_IR) sr_o <= IR_CAPTURE;
    else if (state_i == ST_SHF_IR) sr_o <= {tdi_i, sr_o[IR_W-1:1]};

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) ir_o <= OP_IDCODE;
    else if (state_i == ST_TLR)    ir_o <= OP_IDCODE;
    else if (state_i == ST_UPD_IR) ir_o <= sr_o;
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int          BSR_LEN      = 8,
  parameter logic [31:0] IDCODE_VAL   = 32'h2A0B_40DD,
  parameter logic [31:0] USERCODE_VAL = 32'h5EED_0C01
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  tap_state_e         state_i,
  input  dr_sel_e            sel_i,
  input  logic               tdi_i,
  input  logic [BSR_LEN-1:0] pin_in_i,
  output logic               so_o,
  output logic [BSR_LEN-1:0] upd_o
);
  localparam int ID_W = 32;

  logic               byp_q;
  logic [ID_W-1:0]    id_sr;
  logic [BSR_LEN-1:0] bsr_sr, bsr_shift;

  generate
    if (BSR_LEN == 1) begin : g_bsr_one
      assign bsr_shift = tdi_i;
    end else begin : g_bsr_many
      assign bsr_shift = {tdi_i, bsr_sr[BSR_LEN-1:1]};
    end
  endgenerate

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) begin
      byp_q  <= 1'b0;
      id_sr  <= '0;
      bsr_sr <= '0;
      upd_o  <= '0;
    end else begin
      unique case (state_i)
        ST_CAP_DR: begin
          byp_q <= 1'b0;
          if (sel_i == DR_IDCODE)    id_sr <= IDCODE_VAL;
          else if (sel_i == DR_USER) id_sr <= USERCODE_VAL;
          if (sel_i == DR_BSR)       bsr_sr <= pin_in_i;
        end
        ST_SHF_DR: begin
          unique case (sel_i)
            DR_BYPASS:         byp_q  <= tdi_i;
            DR_IDCODE, DR_USER: id_sr <= {tdi_i, id_sr[ID_W-1:1]};
            DR_BSR:            bsr_sr <= bsr_shift;
            default: ;
          endcase
        end
        ST_UPD_DR: if (sel_i == DR_BSR) upd_o <= bsr_sr;
        default: ;
      endcase
    end

  always_comb
    unique case (sel_i)
      DR_IDCODE, DR_USER: so_o = id_sr[0];
      DR_BSR:             so_o = bsr_sr[0];
      default:            so_o = byp_q;
    endcase
endmodule

// File: rtl/jtag_tap.sv
module jtag_tap
  import jtag_tap_pkg::*;
#(
  parameter int          BSR_LEN      = 8,
  parameter logic [31:0] IDCODE_VAL   = 32'h2A0B_40DD,
  parameter logic [31:0] USERCODE_VAL = 32'h5EED_0C01
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               tms_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  output logic               tdo_en_o,
  input  logic [BSR_LEN-1:0] pin_in_i,
  input  logic [BSR_LEN-1:0] core_out_i,
  output logic [BSR_LEN-1:0] pin_out_o,
  output logic               highz_o
);
  tap_state_e         state_q;
  logic [IR_W-1:0]    ir_q, ir_sr;
  logic [BSR_LEN-1:0] bsr_upd;
  dr_sel_e            dr_sel;
  logic               dr_so, extest;

  tap_fsm u_fsm (.tck_i, .rst_ni, .tms_i, .state_o(state_q));

  tap_ir u_ir (.tck_i, .rst_ni, .state_i(state_q), .tdi_i, .ir_o(ir_q), .sr_o(ir_sr));

  always_comb begin
    extest  = 1'b0;
    highz_o = 1'b0;
    unique case (ir_q)
      OP_IDCODE:           dr_sel = DR_IDCODE;
      OP_USERCODE:         dr_sel = DR_USER;
      OP_SAMPLE:           dr_sel = DR_BSR;
      OP_EXTEST:   begin   dr_sel = DR_BSR; extest = 1'b1; end
      OP_HIGHZ:    begin   dr_sel = DR_BYPASS; highz_o = 1'b1; end
      default:             dr_sel = DR_BYPASS;
    endcase
  end

  tap_dr #(
    .BSR_LEN(BSR_LEN), .IDCODE_VAL(IDCODE_VAL), .USERCODE_VAL(USERCODE_VAL)
  ) u_dr (
    .tck_i, .rst_ni, .state_i(state_q), .sel_i(dr_sel), .tdi_i,
    .pin_in_i, .so_o(dr_so), .upd_o(bsr_upd)
  );

  // serial output retimed to the falling edge
  always_ff @(negedge tck_i or negedge rst_ni)
    if (!rst_ni) begin
      tdo_o    <= 1'b0;
      tdo_en_o <= 1'b0;
    end else begin
      tdo_en_o <= (state_q == ST_SHF_IR) || (state_q == ST_SHF_DR);
      tdo_o    <= (state_q == ST_SHF_IR) ? ir_sr[0] :
                  (state_q == ST_SHF_DR) ? dr_so    : 1'b0;
    end

  assign pin_out_o = extest ? bsr_upd : core_out_i;
endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
  import jtag_tap_pkg::*;
#(
  parameter int BSR_LEN = 8
) (
  input logic               tck_i,
  input logic               rst_ni,
  input logic               tms_i,
  input logic               tdo_o,
  input logic               tdo_en_o,
  input logic               highz_o,
  input tap_state_e         state_q,
  input logic [IR_W-1:0]    ir_q,
  input logic [IR_W-1:0]    ir_sr,
  input logic [BSR_LEN-1:0] bsr_upd
);
  logic [2:0] ones_q;

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni)           ones_q <= '0;
    else if (!tms_i)       ones_q <= '0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;

  a_r1_five_ones_reset: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ones_q == 3'd5) |-> (state_q == ST_TLR));

  a_r2_tlr_loads_idcode: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_TLR) |=> (ir_q == OP_IDCODE));

  a_r3_capture_ir_pattern: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_CAP_IR) |=> (ir_sr[1:0] == 2'b01));

  a_r8_highz_after_update_ir: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $rose(highz_o) |-> ($past(state_q) == ST_UPD_IR));

  a_r11_tdo_en_in_shift: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o == ((state_q == ST_SHF_DR) || (state_q == ST_SHF_IR)));

  a_r11_tdo_quiet: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !tdo_en_o |-> !tdo_o);

  a_r12_hold_only_on_update: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q != ST_UPD_DR) |=> $stable(bsr_upd));
endmodule

bind jtag_tap jtag_tap_chk #(.BSR_LEN(BSR_LEN)) u_chk (
  .tck_i(tck_i), .rst_ni(rst_ni), .tms_i(tms_i), .tdo_o(tdo_o),
  .tdo_en_o(tdo_en_o), .highz_o(highz_o), .state_q(state_q),
  .ir_q(ir_q), .ir_sr(ir_sr), .bsr_upd(bsr_upd)
);

// File: tb/jtag_tap_tb.sv
`timescale 1ns/1ps
module jtag_tap_tb;
  localparam int          BSR   = 8;
  localparam logic [31:0] IDV   = 32'h2A0B_40DD;
  localparam logic [31:0] USERV = 32'h5EED_0C01;
  localparam logic [9:0] C_EXT = 10'h000, C_SMP = 10'h005, C_IDC = 10'h006,
                         C_USR = 10'h007, C_HIZ = 10'h00B, C_BYP = 10'h3FF;

  logic tck_i = 1'b0, rst_ni = 1'b0, tms_i = 1'b1, tdi_i = 1'b0;
  logic tdo_o, tdo_en_o, highz_o;
  logic [BSR-1:0] pin_in_i = '0, core_out_i = '0, pin_out_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 tck_i = ~tck_i;

  jtag_tap #(.BSR_LEN(BSR), .IDCODE_VAL(IDV), .USERCODE_VAL(USERV)) u_dut (
    .tck_i, .rst_ni, .tms_i, .tdi_i, .tdo_o, .tdo_en_o,
    .pin_in_i, .core_out_i, .pin_out_o, .highz_o);

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step(input logic tms, input logic tdi, output logic tdo);
    @(negedge tck_i); #1;
    tdo = tdo_o; tms_i = tms; tdi_i = tdi;
    @(posedge tck_i);
  endtask

  task automatic settle();
    @(negedge tck_i); #1;
  endtask

  task automatic shift_ir(input logic [9:0] code, output logic [9:0] capt);
    logic d;
    step(1, 0, d); step(1, 0, d); step(0, 0, d); step(0, 0, d);
    for (int i = 0; i < 10; i++) begin
      step(i == 9, code[i], d); capt[i] = d;
    end
    step(1, 0, d); step(0, 0, d);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic d;
    dout = '0;
    step(1, 0, d); step(0, 0, d); step(0, 0, d);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], d); dout[i] = d;
    end
    step(1, 0, d); step(0, 0, d);
  endtask

  function automatic bit listed(input logic [9:0] op);
    return op == C_EXT || op == C_SMP || op == C_IDC || op == C_USR ||
           op == C_HIZ || op == C_BYP;
  endfunction

  function automatic int dr_len(input logic [9:0] op);
    if (op == C_IDC || op == C_USR) return 32;
    if (op == C_EXT || op == C_SMP) return BSR;
    return 16;
  endfunction

  function automatic logic [63:0] exp_dr(input logic [9:0] op, input logic [63:0] din,
                                         input logic [BSR-1:0] pins);
    if (op == C_IDC) return {32'h0, IDV};
    if (op == C_USR) return {32'h0, USERV};
    if (op == C_EXT || op == C_SMP) return {{(64-BSR){1'b0}}, pins};
    return {48'h0, din[14:0], 1'b0};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [9:0]  capt, op;
    logic [63:0] dout, din;
    logic [BSR-1:0] hold, q;
    logic d;
    void'($urandom(32'd1149));

    core_out_i = 8'hA5;
    repeat (3) @(posedge tck_i);
    settle();
    chk("R2 reset highz", highz_o, 0);
    chk("R11 reset tdo_en", tdo_en_o, 0);
    chk("R11 reset tdo", tdo_o, 0);
    chk("R2 reset pin_out", pin_out_o, core_out_i);
    rst_ni = 1'b1;
    step(0, 0, d);

    shift_dr(32, 64'h0, dout);
    chk("R5 R2 idcode after reset", dout, {32'h0, IDV});
    settle();
    chk("R11 tdo_en idle", tdo_en_o, 0);

    shift_ir(C_USR, capt);
    chk("R3 capture-ir pattern", capt, 10'b00_0000_0001);
    shift_dr(32, 64'h0, dout);
    chk("R6 R4 usercode", dout, {32'h0, USERV});

    shift_ir(C_HIZ, capt);
    settle();
    chk("R8 highz set", highz_o, 1);
    din = 64'($urandom);
    shift_dr(16, din, dout);
    chk("R8 highz uses bypass", dout, exp_dr(C_HIZ, din, '0));
    chk("R8 pins functional", pin_out_o, core_out_i);

    shift_ir(C_BYP, capt);
    settle();
    chk("R8 highz cleared", highz_o, 0);
    din = 64'($urandom);
    shift_dr(16, din, dout);
    chk("R7 bypass delay", dout, exp_dr(C_BYP, din, '0));

    do op = 10'($urandom); while (listed(op));
    shift_ir(op, capt);
    din = 64'($urandom);
    shift_dr(16, din, dout);
    chk("R7 unlisted as bypass", dout, exp_dr(op, din, '0));

    shift_ir(C_SMP, capt);
    pin_in_i = 8'h3C; hold = 8'h96;
    shift_dr(BSR, {56'h0, hold}, dout);
    chk("R9 sample capture", dout, {56'h0, 8'h3C});
    settle();
    chk("R9 pins stay functional", pin_out_o, core_out_i);

    shift_ir(C_EXT, capt);
    settle();
    chk("R10 extest drives preload", pin_out_o, hold);
    core_out_i = 8'h0F;
    settle();
    chk("R10 core ignored under extest", pin_out_o, hold);

    // R12: scan paused before update leaves the hold value in place
    pin_in_i = 8'hE1; q = 8'h5A;
    step(1, 0, d); step(0, 0, d); step(0, 0, d);
    for (int i = 0; i < BSR; i++) begin
      step(i == BSR - 1, q[i], d); dout[i] = d;
    end
    step(0, 0, d); step(0, 0, d);
    settle();
    chk("R12 hold during pause", pin_out_o, hold);
    chk("R10 extest capture", dout[BSR-1:0], 8'hE1);
    step(1, 0, d); step(1, 0, d); step(0, 0, d);
    settle();
    chk("R10 R12 extest update", pin_out_o, q);
    hold = q;

    // R1: five TMS-high clocks from inside Shift-DR
    step(1, 0, d); step(0, 0, d); step(0, 0, d); step(0, 0, d);
    settle();
    chk("R11 tdo_en in shift", tdo_en_o, 1);
    for (int i = 0; i < 5; i++) step(1, 0, d);
    step(0, 0, d);
    settle();
    chk("R2 tlr releases pins", pin_out_o, core_out_i);
    shift_dr(32, 64'h0, dout);
    chk("R1 five ones -> idcode", dout, {32'h0, IDV});

    for (int it = 0; it < 24; it++) begin
      case ($urandom % 7)
        0: op = C_EXT; 1: op = C_SMP; 2: op = C_IDC; 3: op = C_USR;
        4: op = C_HIZ; 5: op = C_BYP; default: op = 10'($urandom);
      endcase
      core_out_i = 8'($urandom);
      pin_in_i   = 8'($urandom);
      shift_ir(op, capt);
      chk("R3 random capture-ir", capt, 10'b00_0000_0001);
      din = {$urandom, $urandom};
      shift_dr(dr_len(op), din, dout);
      chk("R4 random dr", dout, exp_dr(op, din, pin_in_i));
      if (op == C_EXT || op == C_SMP) hold = din[BSR-1:0];
      settle();
      chk("R10 random pins", pin_out_o, (op == C_EXT) ? hold : core_out_i);
      chk("R8 random highz", highz_o, op == C_HIZ);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule